// File: doc/BRIEF.md
# Local Bus Handshake Bridge Controller

The controller sits between a system bus that announces transfers with a read strobe or a write strobe and a local device that answers with a four-phase request/acknowledge handshake. It drives three outputs: a device strobe toward the device, an enable for the data transceiver, and an acknowledge back to the bus. Each cycle type moves these outputs through a fixed order of transitions. Once the bus strobe is withdrawn, the bus acknowledge and the device strobe return to zero in the same clock. The controller waits for the device acknowledge to fall before it goes idle again.

The block is a clocked model. The three asynchronous inputs pass through a two-stage synchronizer, and every output comes straight from a register, so each output changes at most once per clock. The read states are `ST_RD_REQ` (strobe device), `ST_RD_XFER` (transceiver on), `ST_RD_ACK` (bus acknowledged), `ST_RD_DOFF` (transceiver off) and `ST_RD_RTZ` (return to zero). The write states are `ST_WR_XFER`, `ST_WR_REQ`, `ST_WR_DOFF`, `ST_WR_ACK` and `ST_WR_RTZ`. Both cycle types start from and end in `ST_IDLE`.
- Waiting transitions:
  - `IDLE->RD_REQ` and `IDLE->WR_XFER` need exactly one strobe and a low device acknowledge.
  - `RD_REQ->RD_XFER` and `WR_REQ->WR_DOFF` wait for the acknowledge to rise.
  - `RD_ACK->RD_DOFF` and `WR_ACK->WR_RTZ` wait for the strobe to fall.
  - `RD_RTZ->IDLE` and `WR_RTZ->IDLE` wait for the acknowledge to fall.
- Unconditional transitions, one clock each: `RD_XFER->RD_ACK`, `RD_DOFF->RD_RTZ`, `WR_XFER->WR_REQ` and `WR_DOFF->WR_ACK`.

An internal coding bit is high from the device-strobe rise of a read until the read strobe is seen low. It separates read states whose port values would otherwise look alike. A one-clock error pulse reports protocol violations by the bus or the device.

Top module: `lbus_bridge_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, all four outputs are 0 after that edge, and the controller restarts in `ST_IDLE` with its synchronizers cleared.
- R2: A change on any of the three inputs, made between two edges, first shows on the outputs after the third rising edge that follows it (two synchronizer stages plus the output register).
- R3: In a read, the device strobe rises first. The transceiver enable rises only after the device acknowledge is seen high. The bus acknowledge rises one clock after the transceiver enable.
- R4: In either cycle type, the bus acknowledge and the device strobe fall in the same clock. In a read, this happens one clock after the transceiver enable falls.
- R5: In a write, the transceiver enable rises, then the device strobe rises one clock later. After the acknowledge is seen high, the transceiver enable falls. One clock after that the bus acknowledge rises. After the write strobe is seen low, the bus acknowledge and the device strobe fall.
- R6: A new cycle starts only from `ST_IDLE`, and only once the device acknowledge of the previous cycle has been seen low. A strobe held high during `ST_RD_RTZ` starts no cycle until then.
- R7: The coding bit is set only while the device strobe is high in a read. It clears only when the read strobe is seen low. In a read, the transceiver enable rises only after the device acknowledge.
- R8: Both strobes seen high together raise the error output and start no cycle: all outputs stay 0.
- R9: A strobe seen low before the bus acknowledge has risen raises the error output. The cycle still runs to completion. This covers `ST_RD_REQ`, `ST_RD_XFER`, `ST_WR_XFER`, `ST_WR_REQ` and `ST_WR_DOFF`.
- R10: A device-acknowledge rise while the device strobe is low, or a fall while it is high, raises the error output. A fall while the strobe is low is not an error.
- R11: `proto_err_o` is high for exactly one clock at the onset of a violation. A violation that persists gives no further pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_strobe_i | input | 1 | Bus read strobe, asynchronous |
| wr_strobe_i | input | 1 | Bus write strobe, asynchronous |
| dev_ack_i | input | 1 | Device acknowledge, asynchronous |
| dev_strobe_o | output | 1 | Request strobe to the device |
| xcvr_en_o | output | 1 | Data transceiver enable |
| bus_ack_o | output | 1 | Acknowledge to the bus |
| proto_err_o | output | 1 | One-clock protocol-violation pulse |

## Verification
Sequence advance and error flagging can land on the same edge. The bench provokes this by dropping the read strobe one clock after raising the device acknowledge. The dropped strobe is then first seen in `ST_RD_XFER`, so the bus acknowledge rise and the error pulse come from the same edge. The bench checks that both are high at the same sample, and that the read then drains through `ST_RD_DOFF` and `ST_RD_RTZ` as usual. A behavioural reference model, kept in step every clock, judges all other cycles, including the paired fall of the bus acknowledge and the device strobe.

// File: rtl/lbb_pkg.sv
package lbb_pkg;

    typedef enum logic [3:0] {
        ST_IDLE    = 4'd0,
        ST_RD_REQ  = 4'd1,
        ST_RD_XFER = 4'd2,
        ST_RD_ACK  = 4'd3,
        ST_RD_DOFF = 4'd4,
        ST_RD_RTZ  = 4'd5,
        ST_WR_XFER = 4'd6,
        ST_WR_REQ  = 4'd7,
        ST_WR_DOFF = 4'd8,
        ST_WR_ACK  = 4'd9,
        ST_WR_RTZ  = 4'd10
    } bridge_state_t;

    typedef struct packed {
        logic lds;
        logic xen;
        logic dtack;
        logic csc;
    } drive_t;

    // Output levels held in each state
    function automatic drive_t state_drive(bridge_state_t s);
        drive_t v;
        v = '0;
        unique case (s)
            ST_RD_REQ:  begin v.lds = 1'b1; v.csc = 1'b1; end
            ST_RD_XFER: begin v.lds = 1'b1; v.xen = 1'b1; v.csc = 1'b1; end
            ST_RD_ACK:  begin v.lds = 1'b1; v.xen = 1'b1; v.dtack = 1'b1; v.csc = 1'b1; end
            ST_RD_DOFF: begin v.lds = 1'b1; v.dtack = 1'b1; end
            ST_WR_XFER: begin v.xen = 1'b1; end
            ST_WR_REQ:  begin v.lds = 1'b1; v.xen = 1'b1; end
            ST_WR_DOFF: begin v.lds = 1'b1; end
            ST_WR_ACK:  begin v.lds = 1'b1; v.dtack = 1'b1; end
            default:    v = '0;
        endcase
        return v;
    endfunction

    // States in which the strobe must still be held (bus acknowledge not yet risen)
    function automatic logic read_hold(bridge_state_t s);
        return (s == ST_RD_REQ) || (s == ST_RD_XFER);
    endfunction

    function automatic logic write_hold(bridge_state_t s);
        return (s == ST_WR_XFER) || (s == ST_WR_REQ) || (s == ST_WR_DOFF);
    endfunction

endpackage

// File: rtl/lbb_sync.sv
module lbb_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] pipe [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[g] <= '0;
                    else        pipe[g] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[g] <= '0;
                    else        pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    assign q_o = pipe[LAST];
endmodule

// File: rtl/lbb_seq.sv
module lbb_seq
    import lbb_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_i,
    input  logic          wr_i,
    input  logic          ack_i,
    output bridge_state_t st_o,
    output logic          lds_o,
    output logic          xen_o,
    output logic          dtack_o
);
    bridge_state_t st_q, st_n;
    drive_t        drv_q;

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (!ack_i && rd_i && !wr_i)      st_n = ST_RD_REQ;
                else if (!ack_i && wr_i && !rd_i) st_n = ST_WR_XFER;
            end
            ST_RD_REQ:  if (ack_i)  st_n = ST_RD_XFER;
            ST_RD_XFER:             st_n = ST_RD_ACK;
            ST_RD_ACK:  if (!rd_i)  st_n = ST_RD_DOFF;
            ST_RD_DOFF:             st_n = ST_RD_RTZ;
            ST_RD_RTZ:  if (!ack_i) st_n = ST_IDLE;
            ST_WR_XFER:             st_n = ST_WR_REQ;
            ST_WR_REQ:  if (ack_i)  st_n = ST_WR_DOFF;
            ST_WR_DOFF:             st_n = ST_WR_ACK;
            ST_WR_ACK:  if (!wr_i)  st_n = ST_WR_RTZ;
            ST_WR_RTZ:  if (!ack_i) st_n = ST_IDLE;
            default:                st_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_n;
    end

    // Output register, loaded from the next state so outputs move with the state
    always_ff @(posedge clk) begin
        if (!rst_n) drv_q <= '0;
        else        drv_q <= state_drive(st_n);
    end

    assign st_o    = st_q;
    assign lds_o   = drv_q.lds;
    assign xen_o   = drv_q.xen;
    assign dtack_o = drv_q.dtack;

    // R3 / R5: bus acknowledge rises only with the device strobe and acknowledge up
    p_dtack_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_q.dtack) |-> ($past(drv_q.lds) && $past(ack_i)));

    // R4: bus acknowledge and device strobe return to zero together
    p_rtz_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_q.dtack) |-> $fell(drv_q.lds));

    // R6: a cycle leaves idle only with the device acknowledge low
    p_start_ack_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_q.lds || drv_q.xen) |-> !$past(ack_i));

    // R7: coding bit only while the device strobe is high
    p_csc_lds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        drv_q.csc |-> drv_q.lds);

    // R7: coding bit clears only after the read strobe is seen low
    p_csc_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_q.csc) |-> !$past(rd_i));

    // R8: both strobes at once never start a cycle
    p_no_start_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && rd_i && wr_i) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/lbb_err_mon.sv
module lbb_err_mon
    import lbb_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  bridge_state_t st_i,
    input  logic          rd_i,
    input  logic          wr_i,
    input  logic          ack_i,
    input  logic          lds_i,
    output logic          err_o
);
    logic ack_d, cond_d, err_q;
    logic both, early, unsol, cond;

    always_comb begin
        both  = rd_i && wr_i;
        early = (read_hold(st_i) && !rd_i) || (write_hold(st_i) && !wr_i);
        unsol = (ack_i ^ ack_d) && (ack_i ^ lds_i);
        cond  = both || early || unsol;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_d  <= 1'b0;
            cond_d <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            ack_d  <= ack_i;
            cond_d <= cond;
            err_q  <= cond && !cond_d;
        end
    end

    assign err_o = err_q;

    // R11: the error output never stays high two clocks in a row
    p_err_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> !err_q);

    // R10: an acknowledge rise with the device strobe low is flagged
    p_unsol_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !ack_d && !lds_i && !cond_d) |=> err_q);
endmodule

// File: rtl/lbus_bridge_ctrl.sv
module lbus_bridge_ctrl
    import lbb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_strobe_i,
    input  logic wr_strobe_i,
    input  logic dev_ack_i,
    output logic dev_strobe_o,
    output logic xcvr_en_o,
    output logic bus_ack_o,
    output logic proto_err_o
);
    localparam int N_IN = 3;

    logic [N_IN-1:0] raw_in, sync_in;
    logic            rd_s, wr_s, ack_s;
    logic            lds;
    bridge_state_t   st;

    assign raw_in = {rd_strobe_i, wr_strobe_i, dev_ack_i};

    lbb_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (sync_in)
    );

    assign rd_s  = sync_in[2];
    assign wr_s  = sync_in[1];
    assign ack_s = sync_in[0];

    lbb_seq i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_i    (rd_s),
        .wr_i    (wr_s),
        .ack_i   (ack_s),
        .st_o    (st),
        .lds_o   (lds),
        .xen_o   (xcvr_en_o),
        .dtack_o (bus_ack_o)
    );

    lbb_err_mon i_err (
        .clk   (clk),
        .rst_n (rst_n),
        .st_i  (st),
        .rd_i  (rd_s),
        .wr_i  (wr_s),
        .ack_i (ack_s),
        .lds_i (lds),
        .err_o (proto_err_o)
    );

    assign dev_strobe_o = lds;
endmodule

// File: tb/test_lbus_bridge_ctrl.sv
module test_lbus_bridge_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd = 1'b0, wr = 1'b0, ak = 1'b0;
    logic lds, xen, dtk, err;
    int   n_chk = 0, n_fail = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    lbus_bridge_ctrl i_lbus_bridge_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_strobe_i  (rd),
        .wr_strobe_i  (wr),
        .dev_ack_i    (ak),
        .dev_strobe_o (lds),
        .xcvr_en_o    (xen),
        .bus_ack_o    (dtk),
        .proto_err_o  (err)
    );

    // Behavioural reference: input delay line and a phase number
    logic [1:0] m_rd = '0, m_wr = '0, m_ak = '0;
    int   phase = 0;
    bit   ak_old = 0, cond_old = 0;
    bit   e_lds = 0, e_xen = 0, e_dtk = 0, e_err = 0;

    always @(posedge clk) begin : model
        bit r, w, a, early, unsol, c;
        if (!rst_n) begin
            m_rd = '0; m_wr = '0; m_ak = '0; phase = 0;
            ak_old = 0; cond_old = 0;
            e_lds = 0; e_xen = 0; e_dtk = 0; e_err = 0;
        end else begin
            r = m_rd[1]; w = m_wr[1]; a = m_ak[1];
            early = ((phase == 1 || phase == 2) && !r) ||
                    ((phase >= 11 && phase <= 13) && !w);
            unsol = (a != ak_old) && (a ? !e_lds : e_lds);
            c = (r && w) || early || unsol;
            e_err = c && !cond_old;
            cond_old = c;
            ak_old = a;
            case (phase)
                0:  if (!a && r && !w) phase = 1; else if (!a && w && !r) phase = 11;
                1:  if (a) phase = 2;
                2:  phase = 3;
                3:  if (!r) phase = 4;
                4:  phase = 5;
                5:  if (!a) phase = 0;
                11: phase = 12;
                12: if (a) phase = 13;
                13: phase = 14;
                14: if (!w) phase = 15;
                15: if (!a) phase = 0;
                default: phase = 0;
            endcase
            e_lds = (phase >= 1 && phase <= 4) || (phase >= 12 && phase <= 14);
            e_xen = (phase == 2 || phase == 3 || phase == 11 || phase == 12);
            e_dtk = (phase == 3 || phase == 4 || phase == 14);
            m_rd = {m_rd[0], rd}; m_wr = {m_wr[0], wr}; m_ak = {m_ak[0], ak};
        end
    end

    // Compare with the model on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_chk++;
            if ({lds, xen, dtk, err} !== {e_lds, e_xen, e_dtk, e_err}) begin
                n_fail++;
                $display("FAIL model R2 R3 R4 R5 R9 R10: got %b expected %b at %0t",
                         {lds, xen, dtk, err}, {e_lds, e_xen, e_dtk, e_err}, $time);
            end
        end
    end

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain_lds;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (!lds) break;
        end
    endtask

    function automatic logic [3:0] outs();
        return {lds, xen, dtk, err};
    endfunction

    initial begin : stim
        step(3);
        chk("R1 reset held", outs(), 4'b0000);
        #1 rst_n = 1'b1;
        step(2);
        chk("R1 after reset", outs(), 4'b0000);

        // Read cycle
        rd = 1'b1;
        step(2); chk("R2 latency", outs(), 4'b0000);
        step(1); chk("R3 strobe first", outs(), 4'b1000);
        ak = 1'b1;
        step(2); chk("R7 enable waits for ack", outs(), 4'b1000);
        step(1); chk("R3 enable", outs(), 4'b1100);
        step(1); chk("R3 bus ack", outs(), 4'b1110);
        rd = 1'b0;
        step(3); chk("R4 enable off", outs(), 4'b1010);
        step(1); chk("R4 paired return", outs(), 4'b0000);
        rd = 1'b1;
        step(5); chk("R6 held strobe ignored", outs(), 4'b0000);
        ak = 1'b0;
        step(3); chk("R6 still idle", outs(), 4'b0000);
        step(1); chk("R6 new read starts", outs(), 4'b1000);
        rd = 1'b0;
        step(3); chk("R9 early read drop", outs(), 4'b1001);
        step(1); chk("R11 single pulse", outs(), 4'b1000);
        ak = 1'b1;
        drain_lds();
        ak = 1'b0;
        step(4); chk("R9 cycle completed", outs(), 4'b0000);

        // Write cycle
        wr = 1'b1;
        step(3); chk("R5 enable first", outs(), 4'b0100);
        step(1); chk("R5 strobe", outs(), 4'b1100);
        ak = 1'b1;
        step(3); chk("R5 enable off", outs(), 4'b1000);
        step(1); chk("R5 bus ack", outs(), 4'b1010);
        wr = 1'b0;
        step(3); chk("R5 R4 paired return", outs(), 4'b0000);
        ak = 1'b0;
        step(4);

        // Both strobes
        rd = 1'b1; wr = 1'b1;
        step(3); chk("R8 both strobes", outs(), 4'b0001);
        step(4); chk("R8 no cycle", outs(), 4'b0000);
        rd = 1'b0; wr = 1'b0;
        step(4);

        // Unsolicited acknowledge
        ak = 1'b1;
        step(3); chk("R10 unsolicited rise", outs(), 4'b0001);
        ak = 1'b0;
        step(4); chk("R10 fall with strobe low", outs(), 4'b0000);

        // Advance and error on the same edge
        rd = 1'b1;
        step(3);
        ak = 1'b1;
        step(1);
        rd = 1'b0;
        step(3); chk("R9 ack and error same edge", outs(), 4'b1111);
        drain_lds();
        ak = 1'b0;
        step(4); chk("R4 read drained", outs(), 4'b0000);

        // Reset in mid cycle
        wr = 1'b1;
        step(4);
        #1 rst_n = 1'b0;
        step(2); chk("R1 mid-cycle reset", outs(), 4'b0000);
        wr = 1'b0;
        #1 rst_n = 1'b1;
        step(5); chk("R1 idle after reset", outs(), 4'b0000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule